// File: doc/BRIEF.md
# IGMP Frame Trap Classifier

This block watches the bytes of each received Ethernet frame as they arrive on a per-port stream and decides, once per frame, whether the frame is an IGMP control message that the CPU must handle. It follows the destination address, the type/length field, an optional LLC/SNAP header and the first bytes of the IP header. When the frame qualifies, the normal forwarding result is replaced with CPU-only delivery on the high-priority queue.

Address-table intervention is handled in the same verdict. The lookup supplies a source-entry and a destination-entry intervention flag, and either one forces CPU-only delivery for any frame. Per-frame side information comes in with the first byte of the frame. This covers the source port, the intervention flags and the forwarding mask from the lookup, and the global enable. The verdict is a registered one-cycle pulse that carries the final port mask.

Top module: `igmp_trap_classifier`

## Requirements
- R1: With `cfg_igmp_en` sampled as 0, no frame is trapped (`out_trap` = 0).
- R2: A frame is trapped only if bit 0 of its first destination byte is 1. This covers multicast and broadcast. Frames with that bit at 0 are never trapped.
- R3: A frame whose source port equals the CPU port index (NPORTS, 14 by default) is never trapped.
- R4: For a trapped frame the verdict has `out_trap` = 1 and `out_hipri` = 1, and `out_mask` has only bit NPORTS set. For any frame that is not trapped, `out_hipri` = 0.
- R5: Bytes 12 and 13 are read as a big-endian type/length value. A value of 0x0600 or more is an EtherType. It must equal 0x0800, and the IP header then starts at byte 14.
- R6: A type/length value of 0x05DC or less selects SNAP framing. Bytes 14 to 19 must be AA AA 03 00 00 00 and bytes 20 and 21 must be 0x0800, and the IP header then starts at byte 22. Values from 0x05DD to 0x05FF never lead to a trap.
- R7: The IP version is bits 7:4 of the first IP byte. For version 4 the byte at IP offset 9 must be 0x02. For version 6 the byte at IP offset 6 must be 0x02. Any other version never leads to a trap.
- R8: If either intervention flag is 1, `out_intervene` = 1 and `out_mask` has only bit NPORTS set, whatever the destination type.
- R9: If the frame is neither trapped nor intervened, `out_mask` equals the forwarding mask given with the first byte.
- R10: Each frame gives exactly one `out_valid` pulse. The pulse comes in the cycle after the decisive IP byte is accepted. If that byte never arrives, the pulse comes in the cycle after the last byte, and the frame is then not trapped. Idle cycles inside a frame do not change the result.
- R11: Enable, source port, intervention flags and forwarding mask are taken only from the first byte's cycle. Changes to them later in the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_igmp_en | input | 1 | Global trap enable, sampled with first byte |
| in_valid | input | 1 | Byte present on in_data |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_eof | input | 1 | Current byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_src_port | input | PORT_W | Ingress port of the frame |
| in_sa_intervene | input | 1 | Source-entry intervention flag |
| in_da_intervene | input | 1 | Destination-entry intervention flag |
| in_fwd_mask | input | NPORTS+1 | Normal forwarding mask, bit NPORTS is the CPU |
| out_valid | output | 1 | One-cycle verdict pulse |
| out_mask | output | NPORTS+1 | Final destination mask |
| out_hipri | output | 1 | Use the high-priority queue |
| out_trap | output | 1 | Frame trapped as IGMP |
| out_intervene | output | 1 | Intervention override applied |

## Verification
The assertions assume that every frame starts with a byte flagged `in_sof`, ends with one flagged `in_eof`, and has both flags on a valid byte. They also assume the source port is within 0 to NPORTS. The stimulus builds every frame as a complete run of flagged bytes and only uses legal port numbers. It puts idle gaps only between valid bytes, and it changes the side inputs only after the first byte, which exercises the sampling rule. The sweep covers every combination of encapsulation, IP version, protocol value, destination type, source, enable and intervention. It also truncates qualifying frames at every length.

// File: rtl/igmp_trap_pkg.sv
package igmp_trap_pkg;

  localparam int unsigned DA_FIRST_OFS = 0;
  localparam int unsigned TL_HI_OFS    = 12;
  localparam int unsigned TL_LO_OFS    = 13;
  localparam int unsigned SNAP_OFS     = 14;
  localparam int unsigned SNAP_LEN     = 6;
  localparam int unsigned SNAP_ET_HI   = 20;
  localparam int unsigned SNAP_ET_LO   = 21;
  localparam int unsigned ETH2_IP_OFS  = 14;
  localparam int unsigned SNAP_IP_OFS  = 22;
  localparam int unsigned V4_PROTO_OFS = 9;
  localparam int unsigned V6_NEXT_OFS  = 6;

  localparam logic [15:0] ETYPE_IP   = 16'h0800;
  localparam logic [15:0] ETYPE_MIN  = 16'h0600;
  localparam logic [15:0] LENGTH_MAX = 16'h05DC;
  localparam logic [7:0]  PROTO_IGMP = 8'h02;
  localparam logic [3:0]  IP_VER4    = 4'd4;
  localparam logic [3:0]  IP_VER6    = 4'd6;

  typedef enum logic [1:0] {
    ENC_NONE = 2'd0,
    ENC_ETH2 = 2'd1,
    ENC_SNAP = 2'd2
  } encap_e;

  function automatic logic [7:0] snap_hdr_byte(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: snap_hdr_byte = 8'hAA;
      3'd2:       snap_hdr_byte = 8'h03;
      default:    snap_hdr_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/igmp_byte_cursor.sv
module igmp_byte_cursor #(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic [POS_W-1:0] cur_idx
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;

  always_comb cur_idx = in_sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (in_valid) begin
      pos_q <= (cur_idx == POS_MAX) ? cur_idx : cur_idx + 1'b1;
    end
  end

endmodule

// File: rtl/igmp_hdr_match.sv
module igmp_hdr_match
  import igmp_trap_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [POS_W-1:0] cur_idx,
  output logic             dec_fire,
  output logic             dec_igmp,
  output logic             da_group
);

  localparam logic [POS_W-1:0] IDX_DA0    = POS_W'(DA_FIRST_OFS);
  localparam logic [POS_W-1:0] IDX_TL_HI  = POS_W'(TL_HI_OFS);
  localparam logic [POS_W-1:0] IDX_TL_LO  = POS_W'(TL_LO_OFS);
  localparam logic [POS_W-1:0] IDX_SNAP0  = POS_W'(SNAP_OFS);
  localparam logic [POS_W-1:0] IDX_SNAPN  = POS_W'(SNAP_OFS + SNAP_LEN);
  localparam logic [POS_W-1:0] IDX_ET_HI  = POS_W'(SNAP_ET_HI);
  localparam logic [POS_W-1:0] IDX_ET_LO  = POS_W'(SNAP_ET_LO);
  localparam logic [POS_W-1:0] BASE_ETH2  = POS_W'(ETH2_IP_OFS);
  localparam logic [POS_W-1:0] BASE_SNAP  = POS_W'(SNAP_IP_OFS);
  localparam logic [POS_W-1:0] OFS_V4     = POS_W'(V4_PROTO_OFS);
  localparam logic [POS_W-1:0] OFS_V6     = POS_W'(V6_NEXT_OFS);

  logic       da_mc_q;
  logic [7:0] tl_hi_q;
  logic [7:0] et_hi_q;
  encap_e     enc_q;
  logic       path_ok_q;
  logic       ver4_q;
  logic       ver6_q;
  logic       done_q;

  logic [POS_W-1:0] ip_base;
  logic [15:0]      tl_word;
  logic [15:0]      snap_et;
  logic             in_snap_win;
  logic             snap_bad;
  logic             ip_hit;
  logic             done_eff;

  always_comb begin
    ip_base     = (enc_q == ENC_SNAP) ? BASE_SNAP : BASE_ETH2;
    tl_word     = {tl_hi_q, in_data};
    snap_et     = {et_hi_q, in_data};
    in_snap_win = (enc_q == ENC_SNAP) && (cur_idx >= IDX_SNAP0) && (cur_idx < IDX_SNAPN);
    snap_bad    = in_data != snap_hdr_byte(3'(cur_idx - IDX_SNAP0));
    ip_hit      = path_ok_q && (enc_q != ENC_NONE) &&
                  ((ver4_q && (cur_idx == ip_base + OFS_V4)) ||
                   (ver6_q && (cur_idx == ip_base + OFS_V6)));
    done_eff    = in_sof ? 1'b0 : done_q;
    dec_fire    = in_valid && !done_eff && (ip_hit || in_eof);
    dec_igmp    = ip_hit && (in_data == PROTO_IGMP);
    da_group    = da_mc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      da_mc_q   <= 1'b0;
      tl_hi_q   <= '0;
      et_hi_q   <= '0;
      enc_q     <= ENC_NONE;
      path_ok_q <= 1'b0;
      ver4_q    <= 1'b0;
      ver6_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (in_valid) begin
      done_q <= done_eff || dec_fire;
      if (cur_idx == IDX_DA0) da_mc_q <= in_data[0];
      if (cur_idx == IDX_TL_HI) tl_hi_q <= in_data;
      if (cur_idx == IDX_TL_LO) begin
        ver4_q <= 1'b0;
        ver6_q <= 1'b0;
        if (tl_word >= ETYPE_MIN) begin
          enc_q     <= ENC_ETH2;
          path_ok_q <= (tl_word == ETYPE_IP);
        end else if (tl_word <= LENGTH_MAX) begin
          enc_q     <= ENC_SNAP;
          path_ok_q <= 1'b1;
        end else begin
          enc_q     <= ENC_NONE;
          path_ok_q <= 1'b0;
        end
      end
      if (in_snap_win && snap_bad) path_ok_q <= 1'b0;
      if (enc_q == ENC_SNAP && cur_idx == IDX_ET_HI) et_hi_q <= in_data;
      if (enc_q == ENC_SNAP && cur_idx == IDX_ET_LO && snap_et != ETYPE_IP) path_ok_q <= 1'b0;
      if (enc_q != ENC_NONE && cur_idx == ip_base) begin
        ver4_q <= (in_data[7:4] == IP_VER4);
        ver6_q <= (in_data[7:4] == IP_VER6);
      end
    end
  end

endmodule

// File: rtl/igmp_verdict.sv
module igmp_verdict #(
  parameter int unsigned NPORTS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_fire,
  input  logic              dec_igmp,
  input  logic              da_group,
  input  logic              igmp_en,
  input  logic              from_cpu,
  input  logic              sa_intervene,
  input  logic              da_intervene,
  input  logic [NPORTS:0]   fwd_mask,
  output logic              out_valid,
  output logic [NPORTS:0]   out_mask,
  output logic              out_hipri,
  output logic              out_trap,
  output logic              out_intervene
);

  localparam int unsigned MASK_W   = NPORTS + 1;
  localparam int unsigned CPU_PORT = NPORTS;

  logic              trap_now;
  logic              interv_now;
  logic              cpu_only;
  logic [MASK_W-1:0] mask_next;

  always_comb begin
    trap_now   = igmp_en && da_group && !from_cpu && dec_igmp;
    interv_now = sa_intervene || da_intervene;
    cpu_only   = trap_now || interv_now;
  end

  for (genvar g = 0; g < MASK_W; g++) begin : g_mask
    if (g == CPU_PORT) begin : g_cpu
      assign mask_next[g] = cpu_only || fwd_mask[g];
    end else begin : g_port
      assign mask_next[g] = !cpu_only && fwd_mask[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      out_hipri     <= 1'b0;
      out_trap      <= 1'b0;
      out_intervene <= 1'b0;
    end else begin
      out_valid <= dec_fire;
      if (dec_fire) begin
        out_mask      <= mask_next;
        out_hipri     <= trap_now;
        out_trap      <= trap_now;
        out_intervene <= interv_now;
      end
    end
  end

endmodule

// File: rtl/igmp_trap_classifier.sv
module igmp_trap_classifier #(
  parameter int unsigned NPORTS = 14,
  parameter int unsigned POS_W  = 6,
  localparam int unsigned PORT_W = $clog2(NPORTS + 1),
  localparam int unsigned MASK_W = NPORTS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_igmp_en,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic [PORT_W-1:0] in_src_port,
  input  logic              in_sa_intervene,
  input  logic              in_da_intervene,
  input  logic [MASK_W-1:0] in_fwd_mask,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  output logic              out_hipri,
  output logic              out_trap,
  output logic              out_intervene
);

  localparam logic [PORT_W-1:0] CPU_ID = PORT_W'(NPORTS);

  logic [POS_W-1:0]  cur_idx;
  logic              dec_fire;
  logic              dec_igmp;
  logic              da_group;

  logic              ctx_en_q;
  logic              ctx_cpu_q;
  logic              ctx_sa_q;
  logic              ctx_da_q;
  logic [MASK_W-1:0] ctx_mask_q;

  logic              first_byte;
  logic              eff_en;
  logic              eff_cpu;
  logic              eff_sa;
  logic              eff_da;
  logic [MASK_W-1:0] eff_mask;

  always_comb begin
    first_byte = in_valid && in_sof;
    eff_en     = first_byte ? cfg_igmp_en : ctx_en_q;
    eff_cpu    = first_byte ? (in_src_port == CPU_ID) : ctx_cpu_q;
    eff_sa     = first_byte ? in_sa_intervene : ctx_sa_q;
    eff_da     = first_byte ? in_da_intervene : ctx_da_q;
    eff_mask   = first_byte ? in_fwd_mask : ctx_mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_en_q   <= 1'b0;
      ctx_cpu_q  <= 1'b0;
      ctx_sa_q   <= 1'b0;
      ctx_da_q   <= 1'b0;
      ctx_mask_q <= '0;
    end else if (first_byte) begin
      ctx_en_q   <= eff_en;
      ctx_cpu_q  <= eff_cpu;
      ctx_sa_q   <= eff_sa;
      ctx_da_q   <= eff_da;
      ctx_mask_q <= eff_mask;
    end
  end

  igmp_byte_cursor #(.POS_W(POS_W)) u_cursor (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .cur_idx  (cur_idx)
  );

  igmp_hdr_match #(.POS_W(POS_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_data  (in_data),
    .cur_idx  (cur_idx),
    .dec_fire (dec_fire),
    .dec_igmp (dec_igmp),
    .da_group (da_group)
  );

  igmp_verdict #(.NPORTS(NPORTS)) u_verdict (
    .clk           (clk),
    .rst           (rst),
    .dec_fire      (dec_fire),
    .dec_igmp      (dec_igmp),
    .da_group      (da_group),
    .igmp_en       (eff_en),
    .from_cpu      (eff_cpu),
    .sa_intervene  (eff_sa),
    .da_intervene  (eff_da),
    .fwd_mask      (eff_mask),
    .out_valid     (out_valid),
    .out_mask      (out_mask),
    .out_hipri     (out_hipri),
    .out_trap      (out_trap),
    .out_intervene (out_intervene)
  );

endmodule

// File: rtl/igmp_trap_checker.sv
module igmp_trap_checker #(
  parameter int unsigned NPORTS = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [NPORTS:0] out_mask,
  input logic            out_hipri,
  input logic            out_trap,
  input logic            out_intervene
);

  localparam logic [NPORTS:0] CPU_ONLY = (NPORTS+1)'(1) << NPORTS;

  p_trap_mask_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_trap |-> out_mask == CPU_ONLY);

  p_hipri_only_trap_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hipri |-> out_trap);

  p_interv_mask_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_intervene |-> out_mask == CPU_ONLY);

  p_pulse_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

endmodule

bind igmp_trap_classifier igmp_trap_checker #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_mask      (out_mask),
  .out_hipri     (out_hipri),
  .out_trap      (out_trap),
  .out_intervene (out_intervene)
);

// File: tb/igmp_trap_classifier_test.sv
module igmp_trap_classifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP     = 14;
  localparam int PW     = 4;
  localparam int MW     = 15;
  localparam logic [MW-1:0] CPU_BIT = 15'h4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_igmp_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic          in_eof = 1'b0;
  logic [7:0]    in_data = '0;
  logic [PW-1:0] in_src_port = '0;
  logic          in_sa_intervene = 1'b0;
  logic          in_da_intervene = 1'b0;
  logic [MW-1:0] in_fwd_mask = '0;
  logic          out_valid;
  logic [MW-1:0] out_mask;
  logic          out_hipri;
  logic          out_trap;
  logic          out_intervene;

  igmp_trap_classifier #(.NPORTS(NP), .POS_W(6)) uut (
    .clk(clk), .rst(rst), .cfg_igmp_en(cfg_igmp_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_src_port(in_src_port), .in_sa_intervene(in_sa_intervene),
    .in_da_intervene(in_da_intervene), .in_fwd_mask(in_fwd_mask),
    .out_valid(out_valid), .out_mask(out_mask), .out_hipri(out_hipri),
    .out_trap(out_trap), .out_intervene(out_intervene)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] fr [0:63];
  int flen;
  int exp_idx;
  int exp_igmp;
  int npulse, pidx;
  logic [MW-1:0] cap_mask;
  logic cap_hipri, cap_trap, cap_interv;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // enc: 0 Ethernet II IP, 1 SNAP, 2 SNAP header corrupted, 3 type 0x05F0, 4 EtherType 0x86DD
  function automatic void build(input int enc, input int ver, input int proto, input int dak);
    int base;
    for (int k = 0; k < 64; k++) fr[k] = 8'(k * 7 + 3);
    fr[0] = (dak == 0) ? 8'h02 : (dak == 1) ? 8'h01 : 8'hFF;
    for (int k = 1; k < 6; k++) fr[k] = (dak == 2) ? 8'hFF : 8'h5E;
    for (int k = 6; k < 12; k++) fr[k] = 8'h22;
    if (enc == 0 || enc == 4) begin
      fr[12] = (enc == 0) ? 8'h08 : 8'h86;
      fr[13] = (enc == 0) ? 8'h00 : 8'hDD;
      base = 14;
    end else begin
      fr[12] = (enc == 3) ? 8'h05 : 8'h00;
      fr[13] = (enc == 3) ? 8'hF0 : 8'h40;
      fr[14] = 8'hAA; fr[15] = 8'hAA; fr[16] = 8'h03;
      fr[17] = 8'h00; fr[18] = (enc == 2) ? 8'h01 : 8'h00; fr[19] = 8'h00;
      fr[20] = 8'h08; fr[21] = 8'h00;
      base = 22;
    end
    fr[base] = 8'(ver << 4) | 8'h05;
    fr[base + ((ver == 6) ? 6 : 9)] = 8'(proto);
    fr[base + ((ver == 6) ? 9 : 6)] = (proto == 2) ? 8'h11 : 8'h02;
    flen = base + 24;
  endfunction

  function automatic void reference();
    int base, d;
    logic [15:0] tl;
    base = -1;
    d = -1;
    tl = {fr[12], fr[13]};
    if (tl >= 16'h0600) begin
      if (tl == 16'h0800) base = 14;
    end else if (tl <= 16'h05DC) begin
      if (fr[14] == 8'hAA && fr[15] == 8'hAA && fr[16] == 8'h03 && fr[17] == 8'h00 &&
          fr[18] == 8'h00 && fr[19] == 8'h00 && {fr[20], fr[21]} == 16'h0800) base = 22;
    end
    if (base >= 0) begin
      if (fr[base][7:4] == 4'd4) d = base + 9;
      else if (fr[base][7:4] == 4'd6) d = base + 6;
    end
    if (d >= 0 && d < flen) begin
      exp_idx = d;
      exp_igmp = (fr[d] == 8'h02) ? 1 : 0;
    end else begin
      exp_idx = flen - 1;
      exp_igmp = 0;
    end
  endfunction

  task automatic sample(input int idx);
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (out_valid) begin
      npulse++;
      pidx = idx;
      cap_mask = out_mask; cap_hipri = out_hipri;
      cap_trap = out_trap; cap_interv = out_intervene;
    end
  endtask

  // Side inputs are scrambled after the first byte (R11)
  task automatic send(input int en, input int src, input int sa, input int da,
                      input logic [MW-1:0] fm, input int gap_at);
    npulse = 0; pidx = -1;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == flen - 1); in_data = fr[i];
      if (i == 0) begin
        cfg_igmp_en = 1'(en); in_src_port = PW'(src);
        in_sa_intervene = 1'(sa); in_da_intervene = 1'(da); in_fwd_mask = fm;
      end else begin
        cfg_igmp_en = ~1'(en); in_src_port = (src == NP) ? PW'(3) : PW'(NP);
        in_sa_intervene = ~1'(sa); in_da_intervene = ~1'(da); in_fwd_mask = ~fm;
      end
      sample(i);
      if (i == gap_at) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        sample(-2);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    sample(-3);
    sample(-4);
  endtask

  task automatic judge(input string tag, input int en, input int src, input int sa,
                       input int da, input logic [MW-1:0] fm);
    int etrap, eiv;
    logic [MW-1:0] emask;
    reference();
    etrap = (en == 1 && fr[0][0] && src != NP && exp_igmp == 1) ? 1 : 0;
    eiv = (sa == 1 || da == 1) ? 1 : 0;
    emask = (etrap == 1 || eiv == 1) ? CPU_BIT : fm;
    chk("R10", "pulse count", npulse, 1);
    chk("R10", "pulse byte", pidx, exp_idx);
    chk(tag, "trap", int'(cap_trap), etrap);
    chk("R4", "hipri", int'(cap_hipri), etrap);
    chk("R8", "intervene", int'(cap_interv), eiv);
    chk((etrap == 1) ? "R4" : (eiv == 1) ? "R8" : "R9/R11", "mask", int'(cap_mask), int'(emask));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    string tag;
    logic [MW-1:0] fm;
    n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    chk("R10", "reset valid", int'(out_valid), 0);
    chk("R9", "reset mask", int'(out_mask), 0);
    chk("R4", "reset trap", int'(out_trap), 0);

    for (int enc = 0; enc < 5; enc++)
      for (int vi = 0; vi < 3; vi++)
        for (int pr = 0; pr < 2; pr++)
          for (int dak = 0; dak < 3; dak++)
            for (int si = 0; si < 2; si++)
              for (int en = 0; en < 2; en++)
                for (int iv = 0; iv < 3; iv++) begin
                  int ver, src;
                  ver = (vi == 0) ? 4 : (vi == 1) ? 6 : 5;
                  src = (si == 0) ? 3 : NP;
                  build(enc, ver, (pr == 0) ? 2 : 17, dak);
                  fm = MW'(n * 32'h1357 + 5);
                  if (en == 0) tag = "R1";
                  else if (dak == 0) tag = "R2";
                  else if (si == 1) tag = "R3";
                  else if (enc >= 1 && enc <= 3) tag = "R6";
                  else if (vi == 2 || pr == 1) tag = "R7";
                  else tag = "R5";
                  send(en, src, (iv == 1) ? 1 : 0, (iv == 2) ? 1 : 0, fm, (n % 3 == 0) ? 4 : -1);
                  judge(tag, en, src, (iv == 1) ? 1 : 0, (iv == 2) ? 1 : 0, fm);
                  n++;
                end

    // Truncated frames at every length (R10)
    for (int enc = 0; enc < 2; enc++)
      for (int vi = 0; vi < 2; vi++) begin
        build(enc, (vi == 0) ? 4 : 6, 2, 1);
        for (int len = 1; len <= ((enc == 0) ? 38 : 46); len++) begin
          build(enc, (vi == 0) ? 4 : 6, 2, 1);
          flen = len;
          fm = MW'(len);
          send(1, 0, 0, 0, fm, (len % 4 == 0) ? 1 : -1);
          judge("R10", 1, 0, 0, 0, fm);
        end
      end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule